// File: doc/BRIEF.md
# CPU Intermittent Clock Gating Controller

This block slows instruction execution without touching the clock that peripherals and the external bus use. A free-running system clock reaches every consumer. For the CPU alone, the block produces a synchronous clock enable, `cpu_clk_en`. When the CPU retires an instruction that touches a register, internal memory, I/O, a peripheral or the external bus, it raises `acc_retire` for one cycle. If intermittent mode is on, the block then holds the CPU enable low for a fixed number of pulses. That stall postpones the start of the CPU's next internal bus cycle. The bus and peripheral logic keep counting on every clock.

A two-bit select picks the stall length: none, 8, 16 or 32 pulses. The select is sampled once, when a stall begins. A saturating accumulator adds the selected length at the start of each stall. Software can add this total to the nominal execution time to estimate the real run time. Clearing the mode enable cuts a stall short.

A two-state machine drives the gating. State RUN holds the enable high. The transition RUN->HALT fires on a qualified strobe and loads the down-counter with the stall length minus one. State HALT holds the enable low. HALT leaves on one of two transitions: HALT->RUN when the down-counter reaches zero, or HALT->RUN (abort) as soon as the mode enable is low.

Top module: `cpu_gate_ctrl`

## Requirements
- R1: While reset is active, and on the first edge after it, `cpu_clk_en` is 1, `halted` is 0 and `corr_cycles` is 0.
- R2: When `mode_en`=1, `cpu_clk_en`=1 and `acc_retire`=1 are all true at a clock edge, and `halt_sel` is not 00, then `cpu_clk_en` is 0 and `halted` is 1 from the next cycle on.
- R3: The stall lasts exactly 8 cycles for `halt_sel`=01, 16 cycles for 10 and 32 cycles for 11. After that, `cpu_clk_en` returns to 1.
- R4: If `halt_sel`=00 or `mode_en`=0, a strobe on `acc_retire` has no effect: `cpu_clk_en` stays 1 and `corr_cycles` does not change.
- R5: A strobe that arrives while `halted`=1 is ignored. It neither lengthens the stall nor adds to `corr_cycles`.
- R6: The value of `halt_sel` at the strobe sets the length of that stall. Changing `halt_sel` during a stall does not alter it.
- R7: Driving `mode_en` to 0 during a stall sets `cpu_clk_en` back to 1 on the next cycle.
- R8: At the start of each stall, `corr_cycles` increases by that stall's full length in pulses. The full length is added even if the stall is later aborted.
- R9: `corr_cycles` saturates at its all-ones value and never wraps.
- R10: `corr_clr`=1 sets `corr_cycles` to 0 on the next edge. In that same cycle it takes priority over an addition.
- R11: A strobe in the first cycle after a stall ends, when `cpu_clk_en` is 1 again, starts a new stall with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, also used by peripherals and the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Intermittent mode enable |
| halt_sel | input | 2 | Stall length select: 00 none, 01 8, 10 16, 11 32 pulses |
| acc_retire | input | 1 | One-cycle strobe when an access-type instruction retires |
| corr_clr | input | 1 | Synchronous clear of the correction accumulator |
| cpu_clk_en | output | 1 | Synchronous enable for the CPU clock |
| halted | output | 1 | High while a stall is in progress |
| corr_cycles | output | CORR_W (32) | Saturating total of stalled pulses |

## Verification
Single stalls are run with each non-zero select. This separates the three lengths and catches an off-by-one at either end of a stall.

Several timed patterns check the ordering rules:
- A second strobe in the middle of a stall shows whether a stall can be extended.
- A select change one cycle into a stall shows whether the select is sampled only at the start.
- A strobe on the first free cycle shows whether back-to-back stalls have a gap.
- Dropping `mode_en` part way through a stall shows the one-cycle release on abort.

Strobes with select 00 and with the mode off should leave both the enable and the accumulator untouched. An 8-bit instance driven alongside the main one shows saturation. A clear issued in the same cycle as a strobe shows that the clear wins over the addition.

// File: rtl/cig_pkg.sv
package cig_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } gate_state_e;
endpackage

// File: rtl/halt_len_decode.sv
module halt_len_decode #(
    parameter int LEN1 = 8,
    parameter int LEN2 = 16,
    parameter int LEN3 = 32,
    parameter int LW   = 6
) (
    input  logic [1:0]    sel,
    output logic [LW-1:0] len
);
    always_comb begin
        unique case (sel)
            2'b00:   len = '0;
            2'b01:   len = LW'(LEN1);
            2'b10:   len = LW'(LEN2);
            default: len = LW'(LEN3);
        endcase
    end
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import cig_pkg::*;
#(
    parameter int LEN3 = 32,
    parameter int LW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          acc_retire,
    input  logic [LW-1:0] len,
    output logic          start,
    output logic          cpu_clk_en,
    output logic          halted
);
    gate_state_e   state, state_d;
    logic [LW-1:0] cnt, cnt_d;

    assign start = (state == ST_RUN) && mode_en && acc_retire && (len != '0);

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_RUN: begin
                if (start) begin
                    state_d = ST_HALT;
                    cnt_d   = len - 1'b1;
                end
            end
            ST_HALT: begin
                if (!mode_en) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (cnt == '0) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        cpu_clk_en = (state == ST_RUN);
        halted     = (state == ST_HALT);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (cnt < LW'(LEN3))); // R3
endmodule

// File: rtl/corr_accum.sv
module corr_accum #(
    parameter int CORR_W = 32,
    parameter int LW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [LW-1:0]     add_val,
    output logic [CORR_W-1:0] total
);
    logic [CORR_W:0]   sum_w;
    logic [CORR_W-1:0] sat_sum;

    always_comb begin
        sum_w   = {1'b0, total} + (CORR_W+1)'(add_val);
        sat_sum = sum_w[CORR_W] ? '1 : sum_w[CORR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      total <= '0;
        else if (clr)    total <= '0;
        else if (add_en) total <= sat_sum;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (total >= $past(total))); // R9
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total == '0)); // R10
endmodule

// File: rtl/cpu_gate_ctrl.sv
module cpu_gate_ctrl #(
    parameter int LEN1   = 8,
    parameter int LEN2   = 16,
    parameter int LEN3   = 32,
    parameter int CORR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic [1:0]        halt_sel,
    input  logic              acc_retire,
    input  logic              corr_clr,
    output logic              cpu_clk_en,
    output logic              halted,
    output logic [CORR_W-1:0] corr_cycles
);
    localparam int LW = $clog2(LEN3 + 1);

    logic [LW-1:0] len;
    logic          start;

    halt_len_decode #(.LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3), .LW(LW)) u_dec (
        .sel (halt_sel),
        .len (len)
    );

    gate_fsm #(.LEN3(LEN3), .LW(LW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .acc_retire (acc_retire),
        .len        (len),
        .start      (start),
        .cpu_clk_en (cpu_clk_en),
        .halted     (halted)
    );

    corr_accum #(.CORR_W(CORR_W), .LW(LW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (corr_clr),
        .add_en  (start),
        .add_val (len),
        .total   (corr_cycles)
    );

    AST_START_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && mode_en && acc_retire && halt_sel != 2'b00) |=> halted); // R2
    AST_SEL0_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && halt_sel == 2'b00) |=> cpu_clk_en); // R4
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !mode_en) |=> cpu_clk_en); // R7
    AST_HALT_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !corr_clr) |=> $stable(corr_cycles)); // R5
endmodule

// File: tb/tb_cpu_gate_ctrl.sv
`timescale 1ns/1ps
module tb_cpu_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_en = 1'b0;
    logic [1:0]  halt_sel = 2'b00;
    logic        acc_retire = 1'b0;
    logic        corr_clr = 1'b0;
    logic        en_a, halted_a, en_b, halted_b;
    logic [31:0] corr_a;
    logic [7:0]  corr_b;

    int     checks = 0;
    int     errors = 0;
    int     exp_q[$];
    int     run_len = 0;
    longint exp_corr = 0;
    int     exp_sat = 0;
    bit     done = 1'b0;

    always #10 clk = ~clk;

    cpu_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .halt_sel(halt_sel),
        .acc_retire(acc_retire), .corr_clr(corr_clr),
        .cpu_clk_en(en_a), .halted(halted_a), .corr_cycles(corr_a)
    );

    cpu_gate_ctrl #(.CORR_W(8)) dut_sat (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .halt_sel(halt_sel),
        .acc_retire(acc_retire), .corr_clr(corr_clr),
        .cpu_clk_en(en_b), .halted(halted_b), .corr_cycles(corr_b)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_corr(input int n);
        exp_corr += n;
        exp_sat = (exp_sat + n > 255) ? 255 : exp_sat + n;
    endtask

    task automatic check_corr(input string req);
        chk(corr_a == exp_corr[31:0], req, "corr_cycles", corr_a, exp_corr);
        chk(corr_b == exp_sat[7:0], req, "corr_cycles 8-bit", corr_b, exp_sat);
    endtask

    // driver: issue a stall and push its expected length onto the scoreboard
    task automatic halt_run(input logic [1:0] sel, input int n);
        @(negedge clk);
        halt_sel = sel;
        acc_retire = 1'b1;
        exp_q.push_back(n);
        add_corr(n);
        @(negedge clk);
        acc_retire = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // monitor: measure every stall at the ports and compare with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!en_a) begin
                run_len++;
            end else if (run_len > 0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected stall length", run_len, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(run_len == e, "R3", "stall length", run_len, e);
                end
                run_len = 0;
            end
            chk(en_a == en_b, "R3", "instances agree", en_b, en_a);
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk(en_a == 1'b1, "R1", "cpu_clk_en in reset", en_a, 1);
        chk(halted_a == 1'b0, "R1", "halted in reset", halted_a, 0);
        chk(corr_a == 0, "R1", "corr in reset", corr_a, 0);
        rst_n = 1'b1;
        mode_en = 1'b1;
        idle(2);

        // R4: select 00 ignores strobe
        @(negedge clk); halt_sel = 2'b00; acc_retire = 1'b1;
        @(negedge clk); acc_retire = 1'b0;
        chk(en_a == 1'b1, "R4", "sel 00 enable", en_a, 1);
        idle(1); check_corr("R4");
        // R4: mode off ignores strobe
        @(negedge clk); mode_en = 1'b0; halt_sel = 2'b01; acc_retire = 1'b1;
        @(negedge clk); acc_retire = 1'b0;
        chk(en_a == 1'b1, "R4", "mode off enable", en_a, 1);
        idle(1); check_corr("R4");
        mode_en = 1'b1;

        // R3: each length
        halt_run(2'b01, 8);  idle(2);
        halt_run(2'b10, 16); idle(2);
        halt_run(2'b11, 32); idle(2);
        check_corr("R8");

        // R2: stall visible on the first cycle after the strobe
        @(negedge clk); halt_sel = 2'b01; acc_retire = 1'b1;
        exp_q.push_back(8); add_corr(8);
        @(negedge clk); acc_retire = 1'b0;
        chk(halted_a == 1'b1, "R2", "halted after strobe", halted_a, 1);
        chk(en_a == 1'b0, "R2", "enable after strobe", en_a, 0);
        idle(7); idle(2);

        // R5: strobe inside a stall
        @(negedge clk); halt_sel = 2'b01; acc_retire = 1'b1;
        exp_q.push_back(8); add_corr(8);
        @(negedge clk); acc_retire = 1'b0;
        @(negedge clk); acc_retire = 1'b1;
        @(negedge clk); acc_retire = 1'b0;
        idle(5); idle(2);
        check_corr("R5");

        // R6: select change inside a stall
        @(negedge clk); halt_sel = 2'b01; acc_retire = 1'b1;
        exp_q.push_back(8); add_corr(8);
        @(negedge clk); acc_retire = 1'b0; halt_sel = 2'b11;
        idle(7); idle(2);
        check_corr("R6");

        // R7: abort after 5 stalled cycles, full length still counted (R8)
        @(negedge clk); halt_sel = 2'b11; acc_retire = 1'b1;
        exp_q.push_back(5); add_corr(32);
        @(negedge clk); acc_retire = 1'b0;
        idle(4);
        mode_en = 1'b0;
        @(negedge clk);
        chk(en_a == 1'b1, "R7", "enable after abort", en_a, 1);
        mode_en = 1'b1;
        idle(2);
        check_corr("R8");

        // R11: back-to-back stalls
        halt_run(2'b10, 16);
        halt_run(2'b10, 16);
        idle(2);
        check_corr("R11");

        // R9: drive the 8-bit instance past saturation
        for (int i = 0; i < 4; i++) begin
            halt_run(2'b11, 32);
            idle(1);
        end
        idle(1);
        check_corr("R9");

        // R10: clear in the same cycle as a strobe
        @(negedge clk); corr_clr = 1'b1; halt_sel = 2'b01; acc_retire = 1'b1;
        exp_q.push_back(8);
        exp_corr = 0; exp_sat = 0;
        @(negedge clk); corr_clr = 1'b0; acc_retire = 1'b0;
        check_corr("R10");
        idle(7); idle(2);
        check_corr("R10");

        halt_run(2'b01, 8); idle(2);
        check_corr("R8");

        idle(3);
        chk(exp_q.size() == 0, "R3", "stalls left unobserved", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule